// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against software that stops running. A 16-bit counter advances on every clock cycle in which a clock-enable input is high. When the counter reaches the selected interval length, the block either pulses a one-cycle system reset (watchdog mode) or raises a sticky interrupt flag (interval mode). Software keeps a running watchdog from firing by writing the counter-clear bit before the interval runs out. Software can also stop the count with the hold bit, or switch to interval mode to use the block as a periodic tick source.

Every write to the 16-bit control word must carry the key byte 0x5A in its upper half. A write with any other upper byte is treated as a fault and fires the reset at once. Reading the control word returns 0x69 in the upper byte. This means a value that was read back cannot be written again unchanged. After power-up, and after every reset pulse, the block is armed in watchdog mode with the longest interval selected.

A three-state machine sequences the block:
- COUNT: the counter runs.
- HALT: the counter is frozen by the hold bit.
- FIRE: the one cycle in which the reset output is high.

Its transitions are:
- COUNT→HALT on a keyed write with hold set.
- HALT→COUNT on a keyed write with hold clear.
- COUNT→FIRE on a watchdog-mode expiry or a bad-key write.
- HALT→FIRE on a bad-key write.
- FIRE→COUNT unconditionally.

Top module: `wdog_timer`

## Requirements
- R1: After rst_n is released, ctl_rdata reads 0x6900 (watchdog mode, hold clear, select 00), wdt_rst is low and irq_flag is low.
- R2: ctl_rdata holds the following fields: 0x69 in bits 15:8, hold in bit 7, the spare bits 6, 5 and 2 as last written, mode in bit 4 (1 = interval), select in bits 1:0. Bit 3 (clear) always reads 0.
- R3: A write whose bits 15:8 equal 0x5A updates hold, mode, spare and select. The new value is visible on ctl_rdata in the next cycle.
- R4: A write whose bits 15:8 differ from 0x5A drives wdt_rst high for exactly the following cycle. After that cycle, all control fields are back at their power-up values, irq_flag is low and the counter restarts from zero.
- R5: Select 00, 01, 10 and 11 give interval lengths of 32768, 8192, 512 and 64 enabled clock cycles, counted from zero.
- R6: In watchdog mode (bit 4 = 0), the enabled cycle that completes the interval makes wdt_rst high for exactly one cycle. After that cycle, the control fields hold their power-up values.
- R7: In interval mode (bit 4 = 1), expiry sets irq_flag and never asserts wdt_rst. The counter restarts from zero, and irq_flag stays set until an irq_ack cycle.
- R8: While hold is set, the counter does not advance. Once hold is cleared without a clear, counting resumes from the frozen value.
- R9: A keyed write with bit 3 set zeroes the counter in that cycle. This takes priority over a tick in the same cycle.
- R10: The counter advances only in cycles where tick_en is high.
- R11: A write presented while wdt_rst is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick_en | input | 1 | Count enable; the counter advances only in cycles where it is high |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 16 | Control write data: key byte in 15:8, fields in 7:0 |
| ctl_rdata | output | 16 | Control read value |
| irq_ack | input | 1 | Clears the interval flag |
| irq_flag | output | 1 | Sticky interval-expiry flag |
| wdt_rst | output | 1 | One-cycle system reset pulse |

## Verification
The assertions watch, on every cycle, the following properties:
- The reset pulse never lasts longer than one cycle.
- A bad key is always followed by the pulse.
- The controls revert to their defaults after the pulse.
- The state machine's halt state agrees with the stored hold bit.
- The counter stays frozen whenever hold or a low tick_en should stop it.
- An interval-mode expiry always raises the flag and never the reset.

Only the bench's scenarios can show that each select value produces its exact interval length, and that a clear restarts the full interval. The same holds for the read format, for resumption after hold, and for a write landing in the reset cycle being discarded.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_HALT  = 2'd1,
        ST_FIRE  = 2'd2
    } wd_state_e;

    // Bit positions of the control fields inside the low byte.
    localparam int BIT_HOLD  = 7;
    localparam int BIT_MODE  = 4;
    localparam int BIT_CLEAR = 3;

    typedef struct packed {
        logic       hold;
        logic [1:0] spare_hi;
        logic       itvl_mode;
        logic       spare_lo;
        logic [1:0] sel;
    } wd_cfg_t;

    localparam wd_cfg_t CFG_DEFAULT = '{
        hold: 1'b0, spare_hi: 2'b00, itvl_mode: 1'b0, spare_lo: 1'b0, sel: 2'b00
    };

    // log2 of the interval length for a select code, relative to counter width.
    function automatic int interval_log2(input logic [1:0] sel, input int cnt_w);
        case (sel)
            2'b00:   return cnt_w - 1;
            2'b01:   return cnt_w - 3;
            2'b10:   return cnt_w - 7;
            default: return cnt_w - 10;
        endcase
    endfunction

endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
    import wdog_pkg::*;
#(
    parameter int           CTL_W  = 16,
    parameter logic [7:0]   WR_KEY = 8'h5A,
    parameter logic [7:0]   RD_KEY = 8'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             firing,
    output logic             key_bad,
    output logic             clr_pulse,
    output logic             hold_nxt,
    output logic             itvl_mode,
    output logic [1:0]       sel,
    output logic [CTL_W-1:0] rdata
);

    localparam int KEY_LSB = CTL_W - 8;

    wd_cfg_t cfg_q;
    wd_cfg_t cfg_d;
    logic    key_ok;
    logic    key_match;

    assign key_match = (wdata[CTL_W-1:KEY_LSB] == WR_KEY);
    assign key_ok    = wr && !firing && key_match;
    assign key_bad   = wr && !firing && !key_match;
    assign clr_pulse = key_ok && wdata[BIT_CLEAR];

    always_comb begin
        cfg_d = cfg_q;
        if (firing) begin
            cfg_d = CFG_DEFAULT;
        end else if (key_ok) begin
            cfg_d.hold      = wdata[BIT_HOLD];
            cfg_d.spare_hi  = wdata[6:5];
            cfg_d.itvl_mode = wdata[BIT_MODE];
            cfg_d.spare_lo  = wdata[2];
            cfg_d.sel       = wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_DEFAULT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign hold_nxt  = cfg_d.hold;
    assign itvl_mode = cfg_q.itvl_mode;
    assign sel       = cfg_q.sel;

    always_comb begin
        rdata                 = '0;
        rdata[CTL_W-1:KEY_LSB] = RD_KEY;
        rdata[BIT_HOLD]       = cfg_q.hold;
        rdata[6:5]            = cfg_q.spare_hi;
        rdata[BIT_MODE]       = cfg_q.itvl_mode;
        rdata[BIT_CLEAR]      = 1'b0;
        rdata[2]              = cfg_q.spare_lo;
        rdata[1:0]            = cfg_q.sel;
    end

    AST_DEFAULT_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        firing |=> (cfg_q == CFG_DEFAULT)); // R6

    AST_FIRE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (firing && wr) |=> (rdata[7:0] == 8'h00)); // R11

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       flush,
    input  logic       clr,
    input  logic       tick_en,
    input  logic [1:0] sel,
    output logic       expire
);

    localparam int NSEL = 4;

    logic [CNT_W-1:0] lim_tab [NSEL];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;

    // One terminal count per select code, derived from the counter width.
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        localparam int SH = interval_log2(2'(g), CNT_W);
        assign lim_tab[g] = CNT_W'((64'd1 << SH) - 64'd1);
    end

    assign lim_m1 = lim_tab[sel];
    assign expire = run && tick_en && !clr && !flush && (cnt_q >= lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (flush || clr) begin
            cnt_q <= '0;
        end else if (run && tick_en) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !flush && !clr) |=> $stable(cnt_q)); // R8

    AST_NO_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !flush && !clr) |=> $stable(cnt_q)); // R10

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_bad,
    input  logic hold_nxt,
    input  logic expire,
    input  logic itvl_mode,
    input  logic irq_ack,
    output logic run,
    output logic flush,
    output logic wdt_rst,
    output logic irq_flag
);

    wd_state_e state_q;
    wd_state_e state_d;
    logic      irq_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (key_bad || (expire && !itvl_mode)) state_d = ST_FIRE;
                else if (hold_nxt)                     state_d = ST_HALT;
            end
            ST_HALT: begin
                if (key_bad)       state_d = ST_FIRE;
                else if (!hold_nxt) state_d = ST_COUNT;
            end
            ST_FIRE: state_d = ST_COUNT;
            default: state_d = ST_FIRE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        run     = (state_q == ST_COUNT);
        flush   = (state_q == ST_FIRE);
        wdt_rst = (state_q == ST_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     irq_q <= 1'b0;
        else if (state_q == ST_FIRE)    irq_q <= 1'b0;
        else if (expire && itvl_mode)   irq_q <= 1'b1;
        else if (irq_ack)               irq_q <= 1'b0;
    end

    assign irq_flag = irq_q;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst); // R6

    AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> wdt_rst); // R4

    AST_ITVL_FLAG_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && itvl_mode && !key_bad) |=> (irq_flag && !wdt_rst)); // R7

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int         CNT_W  = 16,
    parameter logic [7:0] WR_KEY = 8'h5A,
    parameter logic [7:0] RD_KEY = 8'h69
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    output logic [15:0] ctl_rdata,
    input  logic        irq_ack,
    output logic        irq_flag,
    output logic        wdt_rst
);

    localparam int CTL_W = 16;

    logic       key_bad;
    logic       clr_pulse;
    logic       hold_nxt;
    logic       itvl_mode;
    logic [1:0] sel;
    logic       run;
    logic       flush;
    logic       expire;

    wdog_ctl_reg #(
        .CTL_W  (CTL_W),
        .WR_KEY (WR_KEY),
        .RD_KEY (RD_KEY)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl_wr),
        .wdata     (ctl_wdata),
        .firing    (flush),
        .key_bad   (key_bad),
        .clr_pulse (clr_pulse),
        .hold_nxt  (hold_nxt),
        .itvl_mode (itvl_mode),
        .sel       (sel),
        .rdata     (ctl_rdata)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .flush   (flush),
        .clr     (clr_pulse),
        .tick_en (tick_en),
        .sel     (sel),
        .expire  (expire)
    );

    wdog_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_bad   (key_bad),
        .hold_nxt  (hold_nxt),
        .expire    (expire),
        .itvl_mode (itvl_mode),
        .irq_ack   (irq_ack),
        .run       (run),
        .flush     (flush),
        .wdt_rst   (wdt_rst),
        .irq_flag  (irq_flag)
    );

    AST_HALT_MATCHES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (run == !ctl_rdata[BIT_HOLD])); // R8

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = 16'h0000;
    logic [15:0] ctl_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_flag;
    logic        wdt_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .irq_ack   (irq_ack),
        .irq_flag  (irq_flag),
        .wdt_rst   (wdt_rst)
    );

    // {write word, expected readback}
    localparam logic [31:0] VEC [6] = '{
        32'h5A98_6990, 32'h5A03_6903, 32'h5A1A_6912,
        32'h5AFF_69F7, 32'h5A81_6981, 32'h5A00_6900
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] w);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic ack_irq();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", ctl_rdata, 16'h6900);
        chk("R1 wdt_rst", {15'd0, wdt_rst}, 16'd0);
        chk("R1 irq_flag", {15'd0, irq_flag}, 16'd0);

        // R5 R6: default interval of 32768 ticks in watchdog mode
        tick_en = 1'b1;
        repeat (32767) @(negedge clk);
        chk("R5 R6 before 32768", {15'd0, wdt_rst}, 16'd0);
        @(negedge clk);
        chk("R6 pulse at 32768", {15'd0, wdt_rst}, 16'd1);
        @(negedge clk);
        tick_en = 1'b0;
        chk("R6 pulse one cycle", {15'd0, wdt_rst}, 16'd0);
        chk("R6 defaults", ctl_rdata, 16'h6900);

        // R2 R3: table of keyed writes and readbacks
        for (int i = 0; i < 6; i++) begin
            wr_ctl(VEC[i][31:16]);
            chk("R2 R3 readback", ctl_rdata, VEC[i][15:0]);
            chk("R3 no reset", {15'd0, wdt_rst}, 16'd0);
        end

        // R5 R6: select 01 = 8192 in watchdog mode
        wr_ctl(16'h5A09);
        chk("R9 clear reads 0", ctl_rdata, 16'h6901);
        tick_en = 1'b1;
        repeat (8191) @(negedge clk);
        chk("R5 before 8192", {15'd0, wdt_rst}, 16'd0);
        @(negedge clk);
        chk("R5 R6 pulse at 8192", {15'd0, wdt_rst}, 16'd1);
        tick_en = 1'b0;
        @(negedge clk);
        chk("R6 defaults after 8192", ctl_rdata, 16'h6900);

        // R5 R7: select 10 = 512 in interval mode
        wr_ctl(16'h5A1A);
        tick_en = 1'b1;
        repeat (511) @(negedge clk);
        chk("R5 R7 before 512", {15'd0, irq_flag}, 16'd0);
        @(negedge clk);
        tick_en = 1'b0;
        chk("R5 R7 flag at 512", {15'd0, irq_flag}, 16'd1);
        chk("R7 no reset", {15'd0, wdt_rst}, 16'd0);
        repeat (5) @(negedge clk);
        chk("R7 flag sticky", {15'd0, irq_flag}, 16'd1);
        ack_irq();
        chk("R7 ack clears", {15'd0, irq_flag}, 16'd0);

        // R5 R10: select 11 = 64 with tick_en every other cycle
        wr_ctl(16'h5A1B);
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (i == 126) chk("R10 63 ticks", {15'd0, irq_flag}, 16'd0);
            if (i == 127) chk("R5 R10 64 ticks", {15'd0, irq_flag}, 16'd1);
            tick_en = (i % 2 == 0);
        end
        tick_en = 1'b0;
        ack_irq();

        // R9: clear during counting restarts the full interval
        wr_ctl(16'h5A1B);
        tick_en = 1'b1;
        repeat (40) @(negedge clk);
        wr_ctl(16'h5A1B);
        repeat (63) @(negedge clk);
        chk("R9 restarted 63", {15'd0, irq_flag}, 16'd0);
        @(negedge clk);
        chk("R9 restarted 64", {15'd0, irq_flag}, 16'd1);
        tick_en = 1'b0;
        ack_irq();

        // R8: hold freezes, release resumes
        wr_ctl(16'h5A9B);
        chk("R8 hold readback", ctl_rdata, 16'h6993);
        tick_en = 1'b1;
        repeat (200) @(negedge clk);
        chk("R8 frozen", {15'd0, irq_flag}, 16'd0);
        wr_ctl(16'h5A13);
        repeat (63) @(negedge clk);
        chk("R8 resumed 63", {15'd0, irq_flag}, 16'd0);
        @(negedge clk);
        tick_en = 1'b0;
        chk("R8 resumed 64", {15'd0, irq_flag}, 16'd1);

        // R4 R11: bad key fires, write during pulse is dropped
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = 16'h1234;
        @(negedge clk);
        chk("R4 bad key pulse", {15'd0, wdt_rst}, 16'd1);
        ctl_wdata = 16'h5A13;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R4 pulse ends", {15'd0, wdt_rst}, 16'd0);
        chk("R4 R11 defaults", ctl_rdata, 16'h6900);
        chk("R4 flag cleared", {15'd0, irq_flag}, 16'd0);

        // R4: read key used as write key also fires
        wr_ctl(16'h6913);
        chk("R4 read key rejected", {15'd0, wdt_rst}, 16'd1);
        @(negedge clk);
        chk("R4 defaults again", ctl_rdata, 16'h6900);

        finish_run();
    end

endmodule